// File: doc/BRIEF.md
# Local Bus Burst SRAM Controller

This block sits between a 32-bit local bus master and a synchronous burst SRAM. It breaks each burst from the master into a steady series of single SRAM accesses, one per clock. The block owns the low eight word-address lines of the SRAM and drives them from an internal counter. The SRAM takes its upper address lines directly from the bus. When the counter reaches its last value (FFh), the block asks the master to break the burst, so a burst never carries past the counter range.

A cycle starts when the master pulls its address strobe low while the region-hit input is high and the controller is idle. The starting word address is then loaded into the counter. It is taken from the dedicated address lines in non-multiplexed mode, or from the shared address/data lines in multiplexed mode. Write beats start on the next clock and each completes in one cycle. A read first spends one lead cycle issuing its address, because the SRAM returns data one clock after the address. After that, every cycle completes one read beat and issues the next address at the same time.

The controller is a four-state machine:

| State | Meaning |
|---|---|
| `ST_IDLE` | No cycle in progress. |
| `ST_WRITE` | A write beat is completing. |
| `ST_RD_LEAD` | The first read address is being issued. |
| `ST_RD_BEAT` | A read beat is completing and the next address is being prefetched. |

Its transitions are:

| Transition | Path | Condition |
|---|---|---|
| START_WR | `ST_IDLE` -> `ST_WRITE` | Strobe with hit, write cycle. |
| START_RD | `ST_IDLE` -> `ST_RD_LEAD` | Strobe with hit, read cycle. |
| WR_NEXT | `ST_WRITE` -> `ST_WRITE` | Beat is neither the last nor at FFh; the counter increments. |
| WR_END | `ST_WRITE` -> `ST_IDLE` | Last-beat input low, or counter at FFh. |
| RD_FIRST | `ST_RD_LEAD` -> `ST_RD_BEAT` | Always. |
| RD_NEXT | `ST_RD_BEAT` -> `ST_RD_BEAT` | Beat is neither the last nor at FFh; the counter increments. |
| RD_END | `ST_RD_BEAT` -> `ST_IDLE` | Last-beat input low, or counter at FFh. |

Top module: `sbsram_ctrl`

## Requirements
- R1: With `mux_mode`=0, a strobe (`ads_n`=0, `sel_hit`=1) seen in idle loads `la_word` into the counter. The first write beat, or the read lead cycle, drives `ma` equal to that value.
- R2: With `mux_mode`=1, the start address is taken from `lad_word` instead, and `la_word` is ignored.
- R3: Each completed beat that does not end the cycle advances the beat address by exactly one. In write beats and in the read lead cycle, `ma` is the address of the current beat. In read beats, `ma` is the current beat address plus one (the prefetch).
- R4: `bterm_n` is low, together with `ready_n`, exactly on the beat whose address is FFh. The cycle then ends without further beats, even when `blast_n` stays high.
- R5: Write beats begin on the cycle after the strobe. In each write beat, `sram_cs_n`=0 and `ready_n`=0, `sram_oe_n`=1, and `sram_bw_n` equals `be_n`, where bit i enables byte lane i (bits 8i+7..8i). Lanes left disabled keep their old SRAM contents.
- R6: A read spends one lead cycle with `sram_cs_n`=0, `sram_oe_n`=0 and `ready_n`=1. After that, each beat has `ready_n`=0 while the SRAM data of that beat's address is on the bus.
- R7: `sram_bw_n` stays all ones in idle and in read cycles. `sram_oe_n` stays high in idle and in write cycles.
- R8: A strobe with `sel_hit`=0 is ignored. The SRAM strobes stay high and no SRAM location changes.
- R9: After a beat taken with `blast_n`=0, or after the terminate beat, the next cycle has every active-low output high.
- R10: A new strobe is accepted in the first idle cycle right after a cycle ends.
- R11: While `rst` is high at a clock edge, the state returns to idle. All active-low outputs read high and `ma` reads 0 on the following cycle, including when reset lands in the middle of a burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mux_mode | input | 1 | 0 = start address from `la_word`; 1 = from `lad_word` |
| ads_n | input | 1 | Address strobe from the master, active low |
| wr | input | 1 | Cycle direction at strobe: 1 = write, 0 = read |
| blast_n | input | 1 | Last-beat indication from the master, active low |
| sel_hit | input | 1 | Address decode hit for the SRAM region |
| la_word | input | 8 | Word address bits [9:2] from the dedicated address bus |
| lad_word | input | 8 | Word address bits [9:2] from the shared address/data lines |
| be_n | input | 4 | Byte enables from the master, active low, one per lane |
| ma | output | 8 | Low SRAM word address lines |
| sram_cs_n | output | 1 | SRAM chip select, active low |
| sram_oe_n | output | 1 | SRAM output enable, active low |
| sram_bw_n | output | 4 | SRAM byte write enables, active low |
| ready_n | output | 1 | Transfer complete to the master, active low |
| bterm_n | output | 1 | Burst terminate to the master, active low |

## Verification
A strobe is registered at one clock edge, so the first write beat (or the read lead cycle) appears in the cycle after the strobe. The first read beat, with its data, follows one cycle after that. The end of a cycle shows as all outputs high one cycle after the `blast_n` or terminate beat, and reset shows one cycle after the edge where `rst` is high. The bench drives its inputs just after the falling edge and samples 2 ns later. Each sample therefore sees the state registered at the previous rising edge, and the bench steps its expected beat address once per such sample. Read data is checked against a shadow copy of memory that the bench updates only on the write beats it issued.

// File: rtl/sbsram_pkg.sv
package sbsram_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_WRITE   = 2'd1,
        ST_RD_LEAD = 2'd2,
        ST_RD_BEAT = 2'd3
    } ctl_state_e;

endpackage

// File: rtl/sbsram_addr_cnt.sv
module sbsram_addr_cnt #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             inc,
    output logic [CNT_W-1:0] cnt,
    output logic             at_last
);

    localparam logic [CNT_W-1:0] LAST = {CNT_W{1'b1}};

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (inc) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign at_last = (cnt == LAST);

endmodule

// File: rtl/sbsram_fsm.sv
module sbsram_fsm
    import sbsram_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic       wr,
    input  logic       blast_n,
    input  logic       at_last,
    output ctl_state_e state,
    output logic       load,
    output logic       inc
);

    ctl_state_e state_nx;
    logic       beat_end;

    // A beat finishes the cycle on the master's last beat or at the counter end.
    assign beat_end = !blast_n || at_last;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        load     = 1'b0;
        inc      = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (start) begin
                    load     = 1'b1;
                    state_nx = wr ? ST_WRITE : ST_RD_LEAD;
                end
            end
            ST_WRITE: begin
                if (beat_end) begin
                    state_nx = ST_IDLE;
                end else begin
                    inc = 1'b1;
                end
            end
            ST_RD_LEAD: begin
                state_nx = ST_RD_BEAT;
            end
            ST_RD_BEAT: begin
                if (beat_end) begin
                    state_nx = ST_IDLE;
                end else begin
                    inc = 1'b1;
                end
            end
            default: state_nx = ST_IDLE;
        endcase
    end

endmodule

// File: rtl/sbsram_strobes.sv
module sbsram_strobes
    import sbsram_pkg::*;
#(
    parameter int LANES = 4,
    parameter int CNT_W = 8
) (
    input  ctl_state_e       state,
    input  logic [CNT_W-1:0] cnt,
    input  logic             at_last,
    input  logic [LANES-1:0] be_n,
    output logic [CNT_W-1:0] ma,
    output logic             cs_n,
    output logic             oe_n,
    output logic [LANES-1:0] bw_n,
    output logic             ready_n,
    output logic             bterm_n
);

    logic wr_beat;

    always_comb begin
        ma      = cnt;
        cs_n    = 1'b1;
        oe_n    = 1'b1;
        ready_n = 1'b1;
        bterm_n = 1'b1;
        wr_beat = 1'b0;
        unique case (state)
            ST_IDLE: begin
                ma = cnt;
            end
            ST_WRITE: begin
                cs_n    = 1'b0;
                ready_n = 1'b0;
                wr_beat = 1'b1;
                bterm_n = !at_last;
            end
            ST_RD_LEAD: begin
                cs_n = 1'b0;
                oe_n = 1'b0;
            end
            ST_RD_BEAT: begin
                // data for cnt is on the bus; issue the following address
                ma      = cnt + 1'b1;
                cs_n    = 1'b0;
                oe_n    = 1'b0;
                ready_n = 1'b0;
                bterm_n = !at_last;
            end
            default: ma = cnt;
        endcase
    end

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign bw_n[l] = wr_beat ? be_n[l] : 1'b1;
    end

endmodule

// File: rtl/sbsram_ctrl.sv
module sbsram_ctrl
    import sbsram_pkg::*;
#(
    parameter int LANES = 4,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             mux_mode,
    input  logic             ads_n,
    input  logic             wr,
    input  logic             blast_n,
    input  logic             sel_hit,
    input  logic [CNT_W-1:0] la_word,
    input  logic [CNT_W-1:0] lad_word,
    input  logic [LANES-1:0] be_n,
    output logic [CNT_W-1:0] ma,
    output logic             sram_cs_n,
    output logic             sram_oe_n,
    output logic [LANES-1:0] sram_bw_n,
    output logic             ready_n,
    output logic             bterm_n
);

    ctl_state_e       state;
    logic             start;
    logic             load;
    logic             inc;
    logic             at_last;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] start_addr;

    assign start      = !ads_n && sel_hit;
    assign start_addr = mux_mode ? lad_word : la_word;

    sbsram_addr_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .load_val (start_addr),
        .inc      (inc),
        .cnt      (cnt),
        .at_last  (at_last)
    );

    sbsram_fsm u_fsm (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .wr      (wr),
        .blast_n (blast_n),
        .at_last (at_last),
        .state   (state),
        .load    (load),
        .inc     (inc)
    );

    sbsram_strobes #(.LANES(LANES), .CNT_W(CNT_W)) u_out (
        .state   (state),
        .cnt     (cnt),
        .at_last (at_last),
        .be_n    (be_n),
        .ma      (ma),
        .cs_n    (sram_cs_n),
        .oe_n    (sram_oe_n),
        .bw_n    (sram_bw_n),
        .ready_n (ready_n),
        .bterm_n (bterm_n)
    );

endmodule

// File: rtl/sbsram_ctrl_chk.sv
module sbsram_ctrl_chk #(
    parameter int LANES = 4,
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             ads_n,
    input logic             sel_hit,
    input logic             blast_n,
    input logic [CNT_W-1:0] ma,
    input logic             sram_cs_n,
    input logic             sram_oe_n,
    input logic [LANES-1:0] sram_bw_n,
    input logic             ready_n,
    input logic             bterm_n
);

    // R7: writes and output enable never overlap
    p_no_bw_on_read_r7: assert property (@(posedge clk) disable iff (rst)
        !sram_oe_n |-> (&sram_bw_n));

    // R3: a beat that does not end the cycle is followed by a beat one address on
    p_addr_step_r3: assert property (@(posedge clk) disable iff (rst)
        (!ready_n && blast_n && bterm_n) |=> (!ready_n && ma == CNT_W'($past(ma) + 1'b1)));

    // R4: terminate comes with ready and is followed by idle
    p_bterm_end_r4: assert property (@(posedge clk) disable iff (rst)
        !bterm_n |-> (!ready_n && !sram_cs_n));
    p_bterm_idle_r4: assert property (@(posedge clk) disable iff (rst)
        !bterm_n |=> (bterm_n && ready_n && sram_cs_n));

    // R6: the read lead cycle gives no ready
    p_read_lead_r6: assert property (@(posedge clk) disable iff (rst)
        $fell(sram_oe_n) |-> ready_n);

    // R8: chip select leaves idle only after a strobe with a hit
    p_cs_needs_hit_r8: assert property (@(posedge clk) disable iff (rst)
        (sram_cs_n && !(!ads_n && sel_hit)) |=> sram_cs_n);

    // R9: a last beat releases everything on the next cycle
    p_blast_release_r9: assert property (@(posedge clk) disable iff (rst)
        (!ready_n && !blast_n) |=> (ready_n && sram_cs_n && sram_oe_n && (&sram_bw_n)));

    // R11: reset leaves all active-low outputs high
    p_reset_idle_r11: assert property (@(posedge clk)
        rst |=> (sram_cs_n && sram_oe_n && ready_n && bterm_n && (&sram_bw_n) && ma == '0));

endmodule

bind sbsram_ctrl sbsram_ctrl_chk #(.LANES(LANES), .CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .ads_n     (ads_n),
    .sel_hit   (sel_hit),
    .blast_n   (blast_n),
    .ma        (ma),
    .sram_cs_n (sram_cs_n),
    .sram_oe_n (sram_oe_n),
    .sram_bw_n (sram_bw_n),
    .ready_n   (ready_n),
    .bterm_n   (bterm_n)
);

// File: tb/sbsram_ctrl_test.sv
module sbsram_ctrl_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mux_mode = 1'b0;
    logic        ads_n = 1'b1;
    logic        wr = 1'b0;
    logic        blast_n = 1'b1;
    logic        sel_hit = 1'b0;
    logic [7:0]  la_word = '0;
    logic [7:0]  lad_word = '0;
    logic [3:0]  be_n = 4'hF;
    logic [7:0]  ma;
    logic        sram_cs_n, sram_oe_n, ready_n, bterm_n;
    logic [3:0]  sram_bw_n;
    logic [31:0] wdata = '0;
    logic [31:0] q;
    logic [31:0] mem [256];
    logic [31:0] exp_mem [256];
    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;

    sbsram_ctrl uut (
        .clk(clk), .rst(rst), .mux_mode(mux_mode), .ads_n(ads_n), .wr(wr),
        .blast_n(blast_n), .sel_hit(sel_hit), .la_word(la_word), .lad_word(lad_word),
        .be_n(be_n), .ma(ma), .sram_cs_n(sram_cs_n), .sram_oe_n(sram_oe_n),
        .sram_bw_n(sram_bw_n), .ready_n(ready_n), .bterm_n(bterm_n)
    );

    // behavioural synchronous SRAM: one-clock read latency
    always @(posedge clk) begin
        if (!sram_cs_n) begin
            for (int l = 0; l < 4; l++) begin
                if (!sram_bw_n[l]) mem[ma][8*l +: 8] <= wdata[8*l +: 8];
            end
            if (!sram_oe_n) q <= mem[ma];
        end
    end

    function automatic logic [31:0] pat(input logic [7:0] a, input int salt);
        return {a, ~a, a ^ 8'h5A, 8'hC3 ^ a} ^ (32'h9E3779B9 * salt);
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
        end
    endtask

    task automatic chk_idle(input string req);
        chk(req, "cs_n", {31'd0, sram_cs_n}, 32'd1);
        chk(req, "oe_n", {31'd0, sram_oe_n}, 32'd1);
        chk(req, "bw_n", {28'd0, sram_bw_n}, 32'hF);
        chk(req, "ready_n", {31'd0, ready_n}, 32'd1);
        chk(req, "bterm_n", {31'd0, bterm_n}, 32'd1);
    endtask

    // strobe cycle; the controller must still look idle here (R9/R10)
    task automatic strobe(input bit w, input logic [7:0] st, input bit mux, input bit hit);
        @(negedge clk);
        ads_n = 1'b0; wr = w; sel_hit = hit; mux_mode = mux; blast_n = 1'b1; be_n = 4'hF;
        if (mux) begin lad_word = st; la_word = ~st; end
        else     begin la_word = st;  lad_word = ~st; end
        #2;
        chk_idle("R10");
    endtask

    task automatic idle_cycle();
        @(negedge clk);
        ads_n = 1'b1; blast_n = 1'b1; sel_hit = 1'b0; be_n = 4'hF;
        #2;
        chk_idle("R9");
    endtask

    task automatic wr_burst(input logic [7:0] st, input int len, input bit mux,
                            input logic [3:0] ben, input int salt);
        strobe(1'b1, st, mux, 1'b1);
        for (int k = 0; k < 300; k++) begin
            logic [7:0] a;
            a = st + 8'(k);
            @(negedge clk);
            ads_n = 1'b1; sel_hit = 1'b0; la_word = 8'hA5; lad_word = 8'h3C;
            be_n = ben; wdata = pat(a, salt);
            blast_n = (k == len - 1) ? 1'b0 : 1'b1;
            #2;
            chk(k == 0 ? (mux ? "R2" : "R1") : "R3", "wr ma", {24'd0, ma}, {24'd0, a});
            chk("R5", "wr cs_n", {31'd0, sram_cs_n}, 32'd0);
            chk("R5", "wr ready_n", {31'd0, ready_n}, 32'd0);
            chk("R7", "wr oe_n", {31'd0, sram_oe_n}, 32'd1);
            chk("R5", "wr bw_n", {28'd0, sram_bw_n}, {28'd0, ben});
            chk("R4", "wr bterm_n", {31'd0, bterm_n}, {31'd0, (a != 8'hFF)});
            for (int l = 0; l < 4; l++) begin
                if (!ben[l]) exp_mem[a][8*l +: 8] = wdata[8*l +: 8];
            end
            if (k == len - 1 || a == 8'hFF) break;
        end
    endtask

    task automatic rd_burst(input logic [7:0] st, input int len, input bit mux);
        strobe(1'b0, st, mux, 1'b1);
        @(negedge clk);
        ads_n = 1'b1; sel_hit = 1'b0; blast_n = 1'b1; la_word = 8'h5A; lad_word = 8'hC3;
        #2;
        chk(mux ? "R2" : "R1", "lead ma", {24'd0, ma}, {24'd0, st});
        chk("R6", "lead ready_n", {31'd0, ready_n}, 32'd1);
        chk("R6", "lead oe_n", {31'd0, sram_oe_n}, 32'd0);
        chk("R6", "lead cs_n", {31'd0, sram_cs_n}, 32'd0);
        for (int k = 0; k < 300; k++) begin
            logic [7:0] a;
            a = st + 8'(k);
            @(negedge clk);
            blast_n = (k == len - 1) ? 1'b0 : 1'b1;
            #2;
            chk("R6", "rd ready_n", {31'd0, ready_n}, 32'd0);
            chk("R6", "rd data", q, exp_mem[a]);
            chk("R7", "rd bw_n", {28'd0, sram_bw_n}, 32'hF);
            chk("R3", "rd prefetch ma", {24'd0, ma}, {24'd0, 8'(a + 8'd1)});
            chk("R4", "rd bterm_n", {31'd0, bterm_n}, {31'd0, (a != 8'hFF)});
            if (k == len - 1 || a == 8'hFF) break;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog act=timeout exp=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #2;
        chk_idle("R11");
        chk("R11", "reset ma", {24'd0, ma}, 32'd0);
        @(negedge clk);
        rst = 1'b0;

        // fill memory: no last beat, counter end breaks the burst (R4)
        wr_burst(8'h00, 1000, 1'b0, 4'h0, 1);
        idle_cycle();

        // read sweeps, alternating mode, back to back
        for (int s = 0; s < 6; s++) begin
            logic [7:0] starts [6];
            starts = '{8'h00, 8'h05, 8'h7F, 8'hF0, 8'hFC, 8'hFF};
            rd_burst(starts[s], 1, s[0]);
            rd_burst(starts[s], 2, !s[0]);
            rd_burst(starts[s], 7, s[0]);
            rd_burst(starts[s], 40, !s[0]);
        end
        idle_cycle();

        // partial byte-lane writes, every enable pattern (R5)
        for (int i = 0; i < 16; i++) begin
            wr_burst(8'(8'h40 + 3 * i), 3, i[0], 4'(i), 2 + i);
        end
        rd_burst(8'h40, 60, 1'b0);
        idle_cycle();

        // write crossing into the counter end in multiplexed mode (R2, R4)
        wr_burst(8'hFD, 10, 1'b1, 4'h0, 40);
        rd_burst(8'hF8, 20, 1'b1);
        idle_cycle();

        // strobes without a hit are ignored (R8)
        strobe(1'b1, 8'h10, 1'b0, 1'b0);
        @(negedge clk);
        ads_n = 1'b1; be_n = 4'h0; wdata = 32'hDEADBEEF;
        #2;
        chk("R8", "no-hit cs_n", {31'd0, sram_cs_n}, 32'd1);
        chk("R8", "no-hit ready_n", {31'd0, ready_n}, 32'd1);
        strobe(1'b0, 8'h10, 1'b1, 1'b0);
        @(negedge clk);
        ads_n = 1'b1; be_n = 4'hF;
        #2;
        chk("R8", "no-hit rd oe_n", {31'd0, sram_oe_n}, 32'd1);
        rd_burst(8'h0F, 3, 1'b0);

        // reset in the middle of a write burst (R11)
        strobe(1'b1, 8'h20, 1'b0, 1'b1);
        @(negedge clk);
        ads_n = 1'b1; be_n = 4'h0; wdata = pat(8'h20, 77); blast_n = 1'b1;
        exp_mem[8'h20] = wdata;
        @(negedge clk);
        be_n = 4'hF; rst = 1'b1;
        @(negedge clk);
        #2;
        chk_idle("R11");
        chk("R11", "mid reset ma", {24'd0, ma}, 32'd0);
        rst = 1'b0;
        rd_burst(8'h1F, 4, 1'b1);
        idle_cycle();

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule